// File: doc/BRIEF.md
# Instruction Opcode Match Trigger

This block is a debug trigger that watches each instruction offered for execution and compares its encoding against a programmed pattern. Each trigger slot holds a pattern word, a don't-care mask and a control word. The mask lets one slot cover a whole family of opcodes instead of a single encoding. The instruction length comes from the two lowest bits of the fetch word. A compressed instruction has its unused upper half filled with the 16-bit no-op pattern `16'h0001` before the compare. The low bits of the pattern word decide whether the compare covers one half or the whole word. Because of these two rules, a short pattern cannot be mistaken for a full-length opcode.

The core presents an instruction with a valid strobe. In the next cycle each slot reports a one-cycle hit together with its action code. The core acts on the hit before the matched instruction changes any architectural state. Two slots are built side by side and report their hits separately, so a debugger can place one pattern on each. Software programs the slots through a simple write port that carries a slot select, a register address and a data word.

Top module: `opm_trigger_top`

## Requirements
- R1: After reset every slot is disabled with all pattern, mask and control fields zero. All hit and action outputs are low.
- R2: A fetch word whose bits [1:0] equal 2'b11 is a 32-bit instruction. Any other value marks a 16-bit instruction, and its upper 16 bits are replaced by 16'h0001 before the compare, never by zeros.
- R3: For each mask bit, 0 means the matching instruction bit must equal the pattern bit. 1 means that bit is ignored.
- R4: When pattern bits [1:0] equal 2'b11, all 32 bits take part in the compare. Otherwise only bits [15:0] take part.
- R5: The control size field (ctrl bits [2:1]) limits the compare. Code 0 compares bits [7:0] and code 1 compares bits [15:0]. Code 2 (32-bit) and code 3 (48-bit) both compare all 32 presented bits. This limit combines with R4, so a bit takes part only if both rules allow it.
- R6: A hit is registered. It is high for exactly the one cycle after each cycle in which the instruction valid strobe is high and the word matches. There is no hit when the strobe is low.
- R7: When the enable bit (ctrl bit 0) of a slot is 0, that slot's hit stays low.
- R8: The action code (ctrl bits [5:3]) appears on the slot's action output in the hit cycle, and the output is zero otherwise. Codes 0 to 4 are defined. Codes 5 to 7 mean no action, so they produce no hit and a zero action output.
- R9: A write takes effect for instructions presented in later cycles. An instruction presented in the same cycle as a write is compared against the settings from before that write.
- R10: Writes go only to the slot chosen by the select input, at address 0 (pattern), 1 (mask) or 2 (control). Address 3 is ignored. Each slot's hit depends only on its own settings.
- R11: A 16-bit pattern whose mask keeps bits [1:0] never hits a 32-bit instruction, even when that instruction's low half differs from the pattern only in the length bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Slot chosen for the write |
| cfg_addr | input | 2 | Register: 0 pattern, 1 mask, 2 control |
| cfg_wdata | input | 32 | Write data |
| ins_valid | input | 1 | Instruction valid strobe |
| ins_word | input | 32 | Raw fetch word |
| trig_hit | output | NUM_TRIG | One-cycle hit per slot |
| trig_act | output | NUM_TRIG*3 | Action code per slot, zero without a hit |

## Verification
A configuration write and an instruction compare can fall in the same cycle. The R9 rule then decides whether the instruction sees the old or the new settings. The bench provokes this in two ways. It rewrites a slot's pattern in the very cycle that a matching instruction is presented, and it scatters random writes among random instructions. It judges the result by keeping a shadow of the settings that updates only after the expected hit for that cycle has been computed. The same method covers a write to one slot that lands while the other slot is matching.

// File: rtl/opm_pkg.sv
package opm_pkg;
  localparam int IW      = 32;          // fetch word width
  localparam int HW      = 16;          // compressed instruction width
  localparam int ACT_W   = 3;           // action code width
  localparam int SIZE_W  = 2;           // compare-size code width
  localparam int CFG_AW  = 2;           // configuration address width
  localparam logic [HW-1:0] C_NOP_PAD = 16'h0001;

  localparam logic [CFG_AW-1:0] A_PAT  = 2'd0;
  localparam logic [CFG_AW-1:0] A_MASK = 2'd1;
  localparam logic [CFG_AW-1:0] A_CTRL = 2'd2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_48 = 2'd3
  } cmp_size_e;

  typedef struct packed {
    logic [IW-1:0]    pat;
    logic [IW-1:0]    mask;
    logic             en;
    cmp_size_e        size;
    logic [ACT_W-1:0] act;
  } trig_cfg_t;
endpackage

// File: rtl/opm_len_norm.sv
module opm_len_norm
  import opm_pkg::*;
(
  input  logic [IW-1:0] word_i,
  output logic [IW-1:0] norm_o,
  output logic          is32_o
);
  always_comb begin
    is32_o = (word_i[1:0] == 2'b11);
    if (is32_o) begin
      norm_o = word_i;
    end else begin
      norm_o = {C_NOP_PAD, word_i[HW-1:0]};
    end
  end
endmodule

// File: rtl/opm_cfg_regs.sv
module opm_cfg_regs
  import opm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [IW-1:0]     wr_data,
  output trig_cfg_t         cfg_o
);
  trig_cfg_t cfg_q;
  trig_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (wr_addr)
      A_PAT:  cfg_d.pat  = wr_data;
      A_MASK: cfg_d.mask = wr_data;
      A_CTRL: begin
        cfg_d.en   = wr_data[0];
        cfg_d.size = cmp_size_e'(wr_data[SIZE_W:1]);
        cfg_d.act  = wr_data[SIZE_W+1 +: ACT_W];
      end
      default: cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // Settings move only on a write strobe (R9, R10)
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/opm_match_core.sv
module opm_match_core
  import opm_pkg::*;
#(
  parameter int NUM_ACT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trig_cfg_t        cfg_i,
  input  logic             in_valid,
  input  logic [IW-1:0]    norm_i,
  input  logic             is32_i,
  output logic             hit_o,
  output logic [ACT_W-1:0] act_o
);
  localparam logic [ACT_W:0] ACT_LIM = (ACT_W+1)'(NUM_ACT);

  logic [IW-1:0]    width_mask;
  logic [IW-1:0]    care;
  logic             eq;
  logic             act_ok;
  logic             hit_d;
  logic [ACT_W-1:0] act_d;
  logic             hit_q;
  logic [ACT_W-1:0] act_q;

  always_comb begin
    case (cfg_i.size)
      SZ_8:    width_mask = {{(IW-8){1'b0}}, 8'hFF};
      SZ_16:   width_mask = {{(IW-HW){1'b0}}, {HW{1'b1}}};
      default: width_mask = '1;
    endcase
    if (cfg_i.pat[1:0] != 2'b11) begin
      width_mask[IW-1:HW] = '0;
    end
    care   = ~cfg_i.mask & width_mask;
    eq     = (((norm_i ^ cfg_i.pat) & care) == '0);
    act_ok = ({1'b0, cfg_i.act} < ACT_LIM);
    hit_d  = in_valid & cfg_i.en & act_ok & eq;
    act_d  = hit_d ? cfg_i.act : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      act_q <= '0;
    end else begin
      hit_q <= hit_d;
      act_q <= act_d;
    end
  end

  assign hit_o = hit_q;
  assign act_o = act_q;

  assert_hit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(in_valid));
  assert_hit_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(cfg_i.en));
  assert_act_defined_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ({1'b0, act_q} < ACT_LIM));
  assert_act_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_q |-> (act_q == '0));
  assert_cnop_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is32_i) |-> (norm_i[IW-1:HW] == C_NOP_PAD));
  assert_short_pat_no_long_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_d && cfg_i.pat[1:0] != 2'b11 && cfg_i.mask[1:0] == 2'b00) |-> !is32_i);
endmodule

// File: rtl/opm_trigger_top.sv
module opm_trigger_top
  import opm_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int NUM_ACT  = 5,
  parameter int SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [IW-1:0]             cfg_wdata,
  input  logic                      ins_valid,
  input  logic [IW-1:0]             ins_word,
  output logic [NUM_TRIG-1:0]       trig_hit,
  output logic [NUM_TRIG*ACT_W-1:0] trig_act
);
  logic [IW-1:0] norm_word;
  logic          norm_is32;

  opm_len_norm u_norm (
    .word_i (ins_word),
    .norm_o (norm_word),
    .is32_o (norm_is32)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    trig_cfg_t cfg;
    logic      wr_en;

    assign wr_en = cfg_we && (cfg_sel == SEL_W'(g)) && (cfg_addr != 2'd3);

    opm_cfg_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .cfg_o   (cfg)
    );

    opm_match_core #(.NUM_ACT(NUM_ACT)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (cfg),
      .in_valid (ins_valid),
      .norm_i   (norm_word),
      .is32_i   (norm_is32),
      .hit_o    (trig_hit[g]),
      .act_o    (trig_act[g*ACT_W +: ACT_W])
    );
  end
endmodule

// File: tb/opm_trigger_top_tb_top.sv
module opm_trigger_top_tb_top;
  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_word = '0;
  logic [NT-1:0]   trig_hit;
  logic [NT*3-1:0] trig_act;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] sh_pat  [NT];
  logic [31:0] sh_mask [NT];
  logic [5:0]  sh_ctrl [NT];
  logic        exp_hit [NT];
  logic [2:0]  exp_act [NT];
  string       exp_tag = "R1";

  always #2.5 clk = ~clk;

  opm_trigger_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ins_valid(ins_valid),
    .ins_word(ins_word), .trig_hit(trig_hit), .trig_act(trig_act)
  );

  function automatic logic model_hit(logic [31:0] pat, logic [31:0] mask,
                                     logic [5:0] ctrl, logic [31:0] w);
    logic [31:0] nw, wm;
    if (!ctrl[0] || ctrl[5:3] > 3'd4) return 1'b0;          // R7, R8
    nw = (w[1:0] == 2'b11) ? w : {16'h0001, w[15:0]};          // R2
    case (ctrl[2:1])                                           // R5
      2'd0: wm = 32'h0000_00FF;
      2'd1: wm = 32'h0000_FFFF;
      default: wm = 32'hFFFF_FFFF;
    endcase
    if (pat[1:0] != 2'b11) wm &= 32'h0000_FFFF;                // R4
    return (((nw ^ pat) & ~mask & wm) == 32'h0);               // R3
  endfunction

  task automatic compare_outputs();
    for (int t = 0; t < NT; t++) begin
      checks++;
      if (trig_hit[t] !== exp_hit[t] || trig_act[t*3 +: 3] !== exp_act[t]) begin
        errors++;
        $display("FAIL %s slot %0d: hit=%0b act=%0d expected hit=%0b act=%0d",
                 exp_tag, t, trig_hit[t], trig_act[t*3 +: 3], exp_hit[t], exp_act[t]);
      end
    end
  endtask

  // One cycle: check the previous cycle's result, drive new inputs, predict.
  task automatic cyc(input logic we, input logic sel, input logic [1:0] addr,
                     input logic [31:0] data, input logic v, input logic [31:0] w,
                     input string tag);
    @(negedge clk);
    compare_outputs();
    cfg_we = we; cfg_sel = sel; cfg_addr = addr; cfg_wdata = data;
    ins_valid = v; ins_word = w;
    for (int t = 0; t < NT; t++) begin
      exp_hit[t] = v && model_hit(sh_pat[t], sh_mask[t], sh_ctrl[t], w);
      exp_act[t] = exp_hit[t] ? sh_ctrl[t][5:3] : 3'd0;
    end
    exp_tag = tag;
    if (we) begin                                              // R9: after prediction
      case (addr)
        2'd0: sh_pat[sel]  = data;
        2'd1: sh_mask[sel] = data;
        2'd2: sh_ctrl[sel] = data[5:0];
        default: ;                                             // R10: ignored
      endcase
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] addr, input logic [31:0] data);
    cyc(1'b1, sel, addr, data, 1'b0, 32'h0, "cfg");
  endtask

  task automatic ins(input logic [31:0] w, input string tag);
    cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, w, tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int t = 0; t < NT; t++) begin
      sh_pat[t] = '0; sh_mask[t] = '0; sh_ctrl[t] = '0;
      exp_hit[t] = 1'b0; exp_act[t] = '0;
    end
    repeat (3) @(negedge clk);
    compare_outputs();                       // R1: outputs low in reset
    rst_n = 1'b1;
    ins(32'h0000_0000, "R1");                // R1: zero config, no hit
    ins(32'h0000_4501, "R1");

    // 16-bit pattern, size 16, action 1
    wr(0, 2'd0, 32'h0000_4501);
    wr(0, 2'd2, 32'h0000_000B);
    ins(32'h0000_4501, "R4");
    ins(32'hFFFF_4501, "R4");                // upper half ignored
    ins(32'h0000_4503, "R11");               // 32-bit, low half differs only in length bits
    ins(32'hABCD_4503, "R11");
    cyc(1'b0, 0, 2'd0, 0, 1'b0, 32'h0000_4501, "R6");   // no strobe, no hit
    ins(32'h0000_4501, "R6");                // back-to-back hits
    ins(32'h0000_4501, "R6");

    // mask
    wr(0, 2'd1, 32'h0000_0F00);
    ins(32'h0000_4A01, "R3");
    ins(32'h0000_5501, "R3");

    // c.nop fill with 32-bit pattern ignoring the length bits
    wr(0, 2'd0, 32'h0001_1233);
    wr(0, 2'd1, 32'h0000_0003);
    wr(0, 2'd2, 32'h0000_0005);
    ins(32'h0000_1231, "R2");
    wr(0, 2'd0, 32'h0000_1233);
    ins(32'h0000_1231, "R2");                // zero fill would hit here

    // size 8
    wr(0, 2'd1, 32'h0);
    wr(0, 2'd0, 32'h1234_5633);
    wr(0, 2'd2, 32'h0000_0001);
    ins(32'hABCD_EF33, "R5");
    ins(32'hABCD_EF37, "R5");
    wr(0, 2'd2, 32'h0000_0007);              // size 48 compares all bits
    ins(32'h1234_5633, "R5");
    ins(32'h1234_5733, "R5");

    // disable and actions
    wr(0, 2'd2, 32'h0000_0006);
    ins(32'h1234_5633, "R7");
    wr(0, 2'd2, 32'h0000_002D);              // action 5
    ins(32'h1234_5633, "R8");
    wr(0, 2'd2, 32'h0000_003D);              // action 7
    ins(32'h1234_5633, "R8");
    wr(0, 2'd2, 32'h0000_0025);              // action 4
    ins(32'h1234_5633, "R8");

    // write in the same cycle as a matching instruction
    cyc(1'b1, 0, 2'd0, 32'h7777_7777, 1'b1, 32'h1234_5633, "R9");
    ins(32'h1234_5633, "R9");
    ins(32'h7777_7777, "R9");

    // second slot, address 3 ignored
    wr(1, 2'd0, 32'h0000_0011);
    wr(1, 2'd2, 32'h0000_0013);              // size 16, action 2
    wr(1, 2'd3, 32'hFFFF_FFFF);
    ins(32'h0000_0011, "R10");
    ins(32'h7777_7777, "R10");
    cyc(1'b1, 1, 2'd2, 32'h0, 1'b1, 32'h0000_0011, "R10");
    ins(32'h0000_0011, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, w;
      logic s;
      r = $urandom();
      s = r[0];
      if (r[7:4] == 4'd0) begin
        wr(s, r[9:8], (r[9:8] == 2'd1) ? ($urandom() & $urandom()) : $urandom());
      end else begin
        w = (r[6:5] != 2'd0) ? (sh_pat[s] ^ ($urandom() & $urandom() & $urandom())) : $urandom();
        cyc(r[12], r[13], r[15:14], $urandom(), r[11:10] != 2'd0, w, "R6");
      end
    end
    cyc(1'b0, 0, 2'd0, 0, 1'b0, 32'h0, "R6");
    cyc(1'b0, 0, 2'd0, 0, 1'b0, 32'h0, "R6");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule